// File: doc/BRIEF.md
# Address Compare Stop/Sync Unit

This unit lets an operator trap on one instruction address. While the compare mode is stop or sync, every completed instruction raises an exception-branch request towards the halt loop. When the halt loop accepts the request, the unit runs a check routine. The routine latches the address keys into a compare register and compares that register with the instruction address over every bit. It then waits a fixed number of cycles that models the cost of the check. At the end it either lets the CPU continue to the next fetch or stops it.

On an unequal compare the unit gives a continue-to-fetch pulse. On an equal compare it always gives a one-cycle scope sync pulse. In sync mode that pulse comes with a continue-to-fetch pulse, so processing carries on. In stop mode the same pulse comes with a manual-trigger set pulse and no continue, so the CPU halts after the addressed instruction. With the mode off, or set to the reserved code, instruction completions are ignored.

The controller is a finite-state machine with six states:
- **IDLE** waits for a completed instruction.
- **BRANCH** holds the exception branch until the halt loop accepts it.
- **LOAD** latches the keys and the mode.
- **COMPARE** registers the equality result and starts the delay.
- **WAIT** runs the extra check cycles.
- **RESOLVE** drives the one-cycle result pulses.

The transitions are:
- IDLE→BRANCH on a completion in an active mode.
- BRANCH→LOAD on the handshake.
- LOAD→COMPARE and COMPARE→WAIT unconditionally.
- WAIT→RESOLVE when the delay expires.
- RESOLVE→IDLE unconditionally.

Top module: `addr_cmp_unit`

## Requirements
- R1: After reset, all four outputs are low and the unit waits in IDLE.
- R2: The mode codes are 00 for off, 01 for stop, 10 for sync and 11 reserved. With mode 00 or 11, an instruction-complete strobe raises no exception branch and produces no pulse on any output.
- R3: With mode 01 or 10, the exception branch goes high in the cycle after the instruction-complete strobe. It stays high until the cycle after the halt-loop handshake is sampled.
- R4: The address keys are latched in the cycle after the handshake is sampled. A later change to the keys does not affect the compare in progress, and it takes effect at the next check.
- R5: The compare covers every bit of the address, so keys that differ in only the most significant bit or only the least significant bit compare unequal.
- R6: On an unequal compare, continue-to-fetch pulses for one cycle, and neither the sync pulse nor the manual-trigger set goes high.
- R7: On an equal compare, the sync pulse is high for exactly one cycle.
- R8: On an equal compare in sync mode, continue-to-fetch pulses in the same cycle as the sync pulse, and the manual-trigger set stays low.
- R9: On an equal compare in stop mode, the manual-trigger set pulses in the same cycle as the sync pulse, and continue-to-fetch stays low.
- R10: The result pulses appear exactly CHK_DELAY+2 clock edges after the edge that samples the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Compare mode: 00 off, 01 stop, 10 sync, 11 reserved (treated as off) |
| keys_i | input | AW | Operator address keys |
| iaddr_i | input | AW | Instruction address register |
| instr_done_i | input | 1 | One-cycle strobe when an instruction completes |
| chk_go_i | input | 1 | Halt-loop handshake that accepts the exception branch |
| exc_branch_o | output | 1 | Exception-branch request to the halt loop |
| sync_pulse_o | output | 1 | One-cycle scope sync pulse on an equal compare |
| man_trig_set_o | output | 1 | One-cycle set of the manual (stop) trigger |
| fetch_go_o | output | 1 | One-cycle permission to continue to the next fetch |

## Verification
The bench builds the unit with AW=16, SLICE=4 and CHK_DELAY=3. This splits the comparator into four slices, so a difference in the top slice or the bottom slice tests the slice reduction at both ends. A three-cycle delay makes the latency window short enough to count exactly. It is also long enough to change the keys while the check is still waiting and to show that the latched copy is the one used.

// File: rtl/addr_cmp_pkg.sv
package addr_cmp_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_STOP = 2'b01,
        MODE_SYNC = 2'b10,
        MODE_RSVD = 2'b11
    } cmp_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRANCH,
        ST_LOAD,
        ST_CMP,
        ST_WAIT,
        ST_RESOLVE
    } chk_state_e;

    function automatic logic mode_active(input logic [1:0] m);
        return (m == MODE_STOP) || (m == MODE_SYNC);
    endfunction

endpackage

// File: rtl/addr_cmp_match.sv
module addr_cmp_match #(
    parameter int AW    = 16,
    parameter int SLICE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          cmp_i,
    input  logic [AW-1:0] keys_i,
    input  logic [AW-1:0] iaddr_i,
    output logic          eq_o
);
    localparam int NSL = (AW + SLICE - 1) / SLICE;
    localparam int PW  = NSL * SLICE;

    logic [AW-1:0]  key_q;
    logic [PW-1:0]  key_pad;
    logic [PW-1:0]  adr_pad;
    logic [NSL-1:0] slice_eq;
    logic           eq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (load_i) begin
            key_q <= keys_i;
        end
    end

    assign key_pad = PW'(key_q);
    assign adr_pad = PW'(iaddr_i);

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        assign slice_eq[g] = (key_pad[g*SLICE +: SLICE] == adr_pad[g*SLICE +: SLICE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else if (cmp_i) begin
            eq_q <= &slice_eq;
        end
    end

    assign eq_o = eq_q;

    AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(key_q)); // R4

endmodule

// File: rtl/addr_cmp_delay.sv
module addr_cmp_delay #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= CW'(DELAY - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired_o = busy_q && (cnt_q == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= CW'(DELAY - 1))); // R10

endmodule

// File: rtl/addr_cmp_ctrl.sv
module addr_cmp_ctrl
    import addr_cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       instr_done_i,
    input  logic       chk_go_i,
    input  logic       expired_i,
    input  logic       eq_i,
    output logic       load_o,
    output logic       cmp_o,
    output logic       start_o,
    output logic       exc_branch_o,
    output logic       sync_pulse_o,
    output logic       man_trig_set_o,
    output logic       fetch_go_o
);
    chk_state_e state_q, state_d;
    logic [1:0] mode_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (instr_done_i && mode_active(mode_i)) state_d = ST_BRANCH;
            ST_BRANCH:  if (chk_go_i) state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_CMP;
            ST_CMP:     state_d = ST_WAIT;
            ST_WAIT:    if (expired_i) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_OFF;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOAD) begin
                mode_q <= mode_i;
            end
        end
    end

    always_comb begin
        load_o         = 1'b0;
        cmp_o          = 1'b0;
        start_o        = 1'b0;
        exc_branch_o   = 1'b0;
        sync_pulse_o   = 1'b0;
        man_trig_set_o = 1'b0;
        fetch_go_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_BRANCH:  exc_branch_o = 1'b1;
            ST_LOAD:    load_o = 1'b1;
            ST_CMP: begin
                cmp_o   = 1'b1;
                start_o = 1'b1;
            end
            ST_WAIT:    ;
            ST_RESOLVE: begin
                sync_pulse_o   = eq_i;
                man_trig_set_o = eq_i && (mode_q == MODE_STOP);
                fetch_go_o     = !eq_i || (mode_q == MODE_SYNC);
            end
            default:    ;
        endcase
    end

    AST_OFF_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !mode_active(mode_i)) |=> !exc_branch_o); // R2
    AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_branch_o && !chk_go_i) |=> exc_branch_o); // R3
    AST_BRANCH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && instr_done_i && mode_active(mode_i)) |=> exc_branch_o); // R3

endmodule

// File: rtl/addr_cmp_unit.sv
module addr_cmp_unit #(
    parameter int AW        = 16,
    parameter int SLICE     = 4,
    parameter int CHK_DELAY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] keys_i,
    input  logic [AW-1:0] iaddr_i,
    input  logic          instr_done_i,
    input  logic          chk_go_i,
    output logic          exc_branch_o,
    output logic          sync_pulse_o,
    output logic          man_trig_set_o,
    output logic          fetch_go_o
);
    logic load, cmp, start, expired, eq;

    addr_cmp_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .instr_done_i   (instr_done_i),
        .chk_go_i       (chk_go_i),
        .expired_i      (expired),
        .eq_i           (eq),
        .load_o         (load),
        .cmp_o          (cmp),
        .start_o        (start),
        .exc_branch_o   (exc_branch_o),
        .sync_pulse_o   (sync_pulse_o),
        .man_trig_set_o (man_trig_set_o),
        .fetch_go_o     (fetch_go_o)
    );

    addr_cmp_match #(.AW(AW), .SLICE(SLICE)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .cmp_i   (cmp),
        .keys_i  (keys_i),
        .iaddr_i (iaddr_i),
        .eq_o    (eq)
    );

    addr_cmp_delay #(.DELAY(CHK_DELAY)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .expired_o (expired)
    );

    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse_o |=> !sync_pulse_o); // R7
    AST_TRIG_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        man_trig_set_o |-> sync_pulse_o); // R9
    AST_TRIG_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(man_trig_set_o && fetch_go_o)); // R9
    AST_NO_PULSE_IN_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        exc_branch_o |-> !(sync_pulse_o || fetch_go_o || man_trig_set_o)); // R6

endmodule

// File: tb/tb_addr_cmp_unit.sv
module tb_addr_cmp_unit;
    localparam int AW = 16;
    localparam int SLICE = 4;
    localparam int D = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] keys = '0;
    logic [AW-1:0] iaddr = '0;
    logic          done = 1'b0;
    logic          go = 1'b0;
    logic          exc, syncp, mtrig, fgo;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    addr_cmp_unit #(.AW(AW), .SLICE(SLICE), .CHK_DELAY(D)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .keys_i(keys), .iaddr_i(iaddr),
        .instr_done_i(done), .chk_go_i(go), .exc_branch_o(exc), .sync_pulse_o(syncp),
        .man_trig_set_o(mtrig), .fetch_go_o(fgo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic t_reset();
        @(negedge clk);
        chk("R1 exc", int'(exc), 0);
        chk("R1 sync", int'(syncp), 0);
        chk("R1 trig", int'(mtrig), 0);
        chk("R1 fetch", int'(fgo), 0);
    endtask

    task automatic t_off(input logic [1:0] m);
        mode = m;
        keys = 16'h1234;
        iaddr = 16'h1234;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        for (int i = 0; i < D + 4; i++) begin
            chk("R2 no branch", int'(exc), 0);
            chk("R2 no pulse", int'({syncp, mtrig, fgo}), 0);
            @(negedge clk);
        end
    endtask

    task automatic run_check(input logic [1:0] m, input logic [AW-1:0] k,
                             input logic [AW-1:0] a, input bit scramble, input string tag);
        logic e_eq, e_fetch, e_trig;
        int n;
        e_eq    = (k == a);
        e_fetch = !e_eq || (m == 2'b10);
        e_trig  = e_eq && (m == 2'b01);
        mode = m;
        keys = k;
        iaddr = a;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk({"R3 branch rise ", tag}, int'(exc), 1);
        @(negedge clk);
        chk({"R3 branch hold ", tag}, int'(exc), 1);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk({"R3 branch drop ", tag}, int'(exc), 0);
        n = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            n = i;
            if (i == 1 && scramble) keys = ~k;
            if (syncp || fgo || mtrig) break;
        end
        chk({"R10 latency ", tag}, n, D + 2);
        chk({"R7 sync ", tag}, int'(syncp), int'(e_eq));
        if (!e_eq) chk({"R6 fetch ", tag}, int'(fgo), 1);
        else if (m == 2'b10) chk({"R8 fetch ", tag}, int'(fgo), int'(e_fetch));
        else chk({"R9 no fetch ", tag}, int'(fgo), int'(e_fetch));
        chk({"R9 trig ", tag}, int'(mtrig), int'(e_trig));
        @(negedge clk);
        chk({"R7 one cycle ", tag}, int'({syncp, mtrig, fgo}), 0);
    endtask

    task automatic t_sync_cases();
        run_check(2'b10, 16'hA5C3, 16'hA5C4, 1'b0, "sync unequal");
        run_check(2'b10, 16'hA5C3, 16'hA5C3, 1'b0, "sync equal");
    endtask

    task automatic t_stop_cases();
        run_check(2'b01, 16'h0F0F, 16'h0F0F, 1'b0, "stop equal");
        run_check(2'b01, 16'h3333, 16'h3332, 1'b0, "stop unequal");
    endtask

    task automatic t_width();
        run_check(2'b01, 16'h8001, 16'h0001, 1'b0, "R5 msb");
        run_check(2'b10, 16'h7FFE, 16'h7FFF, 1'b0, "R5 lsb");
        run_check(2'b10, 16'hFFFF, 16'hFFFF, 1'b0, "R5 all ones");
    endtask

    task automatic t_key_latch();
        run_check(2'b10, 16'h4242, 16'h4242, 1'b1, "R4 latched");
        mode = 2'b10;
        keys = 16'h4243;
        iaddr = 16'h4242;
        run_check(2'b10, 16'h4243, 16'h4242, 1'b0, "R4 next check");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_off(2'b00);
        t_off(2'b11);
        t_sync_cases();
        t_stop_cases();
        t_width();
        t_key_latch();
        t_off(2'b00);
        finish_run();
    end

endmodule